// File: doc/BRIEF.md
# Exception Return Decode-Execute Unit

This unit sits in the execute stage next to the condition evaluator. It recognises the exception-return instruction in two forms: a 32-bit fixed-length word and a 32-bit word made of two compact halfwords, where the first halfword sits in bits [31:16]. For one issue cycle it takes the word and the processor context, and one clock later it presents the whole outcome on registered outputs. The outcome is one of the following:

- a branch to the return address with a new status word,
- a status-only reload when the core is halted for debug,
- an undefined-instruction signal,
- a no-operation.

A separate flag marks results the architecture leaves unpredictable.

The core is in one of two contexts. In normal execution the instruction branches and restores status. The return address comes from the hypervisor link register in hypervisor mode and from the general link register in every other mode. In the debug-halted context only the compact form is meaningful. It reloads status without branching, clears the conditional-block field, selects compact instruction state and pulses a strobe that tells debug logic to refresh its state flags.

A reduced legality check guards every status reload. If the saved mode field is not a known mode, or it would raise privilege, the current mode is kept and an illegal-state bit is set in the new status word.

The outcome is held in a small state machine. The state register holds the outcome class of the last cycle:

- ST_IDLE: nothing issued, or the instruction has no effect.
- ST_RETURN: branch and restore.
- ST_DBG_RETURN: status reload while halted.
- ST_UNDEF: undefined instruction.
- ST_NOP: no operation.

Every state can move to every other state on each clock. The target state is picked only from the inputs of the cycle just ending. When `issue_i` is low the next state is ST_IDLE.

Top module: `xret_unit`

## Requirements
- R1: A fixed-length word is recognised only when bits[27:20]=0x16, bits[7:4]=0x6 and bits[31:28]≠0xF. Any other word, with `enc_compact_i`=0, produces no outcome: all outputs are low in the following cycle.
- R2: A compact word is recognised when bits[31:16]=0xF3DE, bit15=1, bit14=0, bit12=0 and bits[7:0]=0. Any other word, with `enc_compact_i`=1, produces no outcome.
- R3: Should-be bits are bits[19:8]=0 and bits[3:0]=0xE for the fixed form, and bit13=0 and bits[11:8]=0xF for the compact form. Any mismatch sets `unpred_o` and the instruction still decodes.
- R4: In normal execution with the condition passed and a mode other than User or System, `br_take_o` rises one cycle after issue. `br_target_o` is `hyp_link_i` in Hyp mode (11010) and `gp_link_i` in any other mode.
- R5: Status layout: mode in bits[4:0], compact-state bit in bit 5, conditional-block field in bits[15:8], illegal-state bit in bit 20, flags in bits[31:27]. On a legal normal return, `status_o` equals `saved_status_i` and `status_load_o` is high.
- R6: In normal execution with `cond_pass_i` low the instruction has no effect.
- R7: In User (10000) or System (11111) mode outside debug, the result is `undef_o` (parameter USR_SYS_UNDEF=1, the default) or `nop_o` (USR_SYS_UNDEF=0). `unpred_o` is also set and there is no branch.
- R8: A compact instance issued while `cb_active_i`=1 and `cb_last_i`=0 in normal execution sets `unpred_o`.
- R9: While halted, a compact instance gives `undef_o` in User mode. In System mode it gives `unpred_o` plus the R7 choice. In any other mode it reloads status with no branch and pulses `dbg_upd_o`.
- R10: A debug status reload forces the conditional-block field to 0, the compact-state bit to 1 and the flag bits to 0.
- R11: A fixed-length instance issued while halted gives `undef_o`.
- R12: The following saved modes are illegal: any mode outside {10000, 10001, 10010, 10011, 10111, 11010, 11011, 11111}, and any mode whose level exceeds the current one (User 0, Hyp 2, the others 1). For an illegal saved mode the reload keeps the current mode and sets bit 20.
- R13: After reset, and in any cycle after one with `issue_i` low, all outputs are zero. Target and status read zero whenever they are not being loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue_i | input | 1 | Instruction word valid this cycle |
| instr_i | input | 32 | Instruction word (compact: first halfword in [31:16]) |
| enc_compact_i | input | 1 | 1 = compact two-halfword form |
| cond_pass_i | input | 1 | Condition evaluator result |
| cur_mode_i | input | 5 | Current processor mode |
| halted_i | input | 1 | Core halted for debug |
| cb_active_i | input | 1 | Inside a conditional block |
| cb_last_i | input | 1 | Last instruction of the conditional block |
| hyp_link_i | input | 32 | Hypervisor link register |
| gp_link_i | input | 32 | General link register |
| saved_status_i | input | 32 | Saved status of the current mode |
| br_take_o | output | 1 | Branch strobe |
| br_target_o | output | 32 | Branch target |
| status_load_o | output | 1 | Load `status_o` into the status register |
| status_o | output | 32 | New status word |
| undef_o | output | 1 | Undefined instruction |
| nop_o | output | 1 | Executes as no-operation |
| unpred_o | output | 1 | Unpredictable case detected |
| dbg_upd_o | output | 1 | Debug state flags refresh strobe |

## Verification
Directed words come first. They separate recognition from rejection, with a condition field of 0xF and single-bit opcode corruptions in both forms. Return-register selection is tried in Hyp and in supervisor mode. Should-be bits are flipped one at a time, which shows that the unpredictable flag is independent of decoding.

Random words are then drawn from canonical encodings, canonical encodings with corrupted should-be bits, and arbitrary values. These are mixed with modes that include illegal encodings, halted and running contexts, and conditional-block positions. Together they cover the crossings between the User/System rule, the debug-return forcing and the privilege-raise check.

// File: rtl/xret_pkg.sv
`timescale 1ns/1ps
package xret_pkg;
    localparam int XLEN   = 32;
    localparam int MODE_W = 5;

    localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
    localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
    localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
    localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
    localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
    localparam logic [MODE_W-1:0] MODE_HYP = 5'b11010;
    localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
    localparam logic [MODE_W-1:0] MODE_SYS = 5'b11111;

    localparam int ST_CSTATE = 5;
    localparam int CB_LO     = 8;
    localparam int CB_HI     = 15;
    localparam int ST_ILL    = 20;
    localparam int FLG_LO    = 27;
    localparam int FLG_HI    = 31;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RETURN,
        ST_DBG_RETURN,
        ST_UNDEF,
        ST_NOP
    } xret_state_e;

    function automatic logic mode_known(input logic [MODE_W-1:0] m);
        case (m)
            MODE_USR, MODE_FIQ, MODE_IRQ, MODE_SVC,
            MODE_ABT, MODE_HYP, MODE_UND, MODE_SYS: mode_known = 1'b1;
            default:                                 mode_known = 1'b0;
        endcase
    endfunction

    function automatic logic [1:0] mode_level(input logic [MODE_W-1:0] m);
        if (m == MODE_USR)      mode_level = 2'd0;
        else if (m == MODE_HYP) mode_level = 2'd2;
        else                    mode_level = 2'd1;
    endfunction
endpackage

// File: rtl/xret_decode.sv
`timescale 1ns/1ps
module xret_decode
    import xret_pkg::*;
(
    input  logic [XLEN-1:0] word_i,
    input  logic            compact_i,
    output logic            hit_o,
    output logic            sb_err_o
);
    localparam logic [3:0]  COND_NEVER = 4'hF;
    localparam logic [15:0] CPT_FIRST  = 16'hF3DE;

    logic fix_hit, fix_sb, cpt_hit, cpt_sb;

    always_comb begin
        fix_hit = (word_i[31:28] != COND_NEVER) &&
                  (word_i[27:20] == 8'h16) &&
                  (word_i[7:4]   == 4'h6);
        fix_sb  = (word_i[19:8] != 12'h000) || (word_i[3:0] != 4'hE);
        cpt_hit = (word_i[31:16] == CPT_FIRST) &&
                  word_i[15] && !word_i[14] && !word_i[12] &&
                  (word_i[7:0] == 8'h00);
        cpt_sb  = word_i[13] || (word_i[11:8] != 4'hF);
        hit_o    = compact_i ? cpt_hit : fix_hit;
        sb_err_o = compact_i ? cpt_sb  : fix_sb;
    end
endmodule

// File: rtl/xret_legal_chk.sv
`timescale 1ns/1ps
module xret_legal_chk
    import xret_pkg::*;
(
    input  logic [MODE_W-1:0] cur_mode_i,
    input  logic [MODE_W-1:0] tgt_mode_i,
    output logic              illegal_o
);
    logic [1:0] cur_lvl, tgt_lvl;

    always_comb begin
        cur_lvl   = mode_level(cur_mode_i);
        tgt_lvl   = mode_level(tgt_mode_i);
        illegal_o = !mode_known(tgt_mode_i) || (tgt_lvl > cur_lvl);
    end
endmodule

// File: rtl/xret_status_build.sv
`timescale 1ns/1ps
module xret_status_build
    import xret_pkg::*;
(
    input  logic [XLEN-1:0]   saved_i,
    input  logic [MODE_W-1:0] cur_mode_i,
    input  logic              illegal_i,
    input  logic              debug_i,
    output logic [XLEN-1:0]   status_o
);
    always_comb begin
        status_o = saved_i;
        if (illegal_i) begin
            status_o[MODE_W-1:0] = cur_mode_i;
            status_o[ST_ILL]     = 1'b1;
        end
        if (debug_i) begin
            status_o[CB_HI:CB_LO]   = '0;
            status_o[ST_CSTATE]     = 1'b1;
            status_o[FLG_HI:FLG_LO] = '0;
        end
    end
endmodule

// File: rtl/xret_unit.sv
`timescale 1ns/1ps
module xret_unit
    import xret_pkg::*;
#(
    parameter bit USR_SYS_UNDEF = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_i,
    input  logic [XLEN-1:0]   instr_i,
    input  logic              enc_compact_i,
    input  logic              cond_pass_i,
    input  logic [MODE_W-1:0] cur_mode_i,
    input  logic              halted_i,
    input  logic              cb_active_i,
    input  logic              cb_last_i,
    input  logic [XLEN-1:0]   hyp_link_i,
    input  logic [XLEN-1:0]   gp_link_i,
    input  logic [XLEN-1:0]   saved_status_i,
    output logic              br_take_o,
    output logic [XLEN-1:0]   br_target_o,
    output logic              status_load_o,
    output logic [XLEN-1:0]   status_o,
    output logic              undef_o,
    output logic              nop_o,
    output logic              unpred_o,
    output logic              dbg_upd_o
);
    localparam xret_state_e USS_OUT = USR_SYS_UNDEF ? ST_UNDEF : ST_NOP;

    xret_state_e     st_q, st_d;
    logic            unp_q, unp_d;
    logic [XLEN-1:0] tgt_q, sts_q, sts_d;
    logic            hit, sb_err, illegal;
    logic            in_usr, in_sys;

    xret_decode u_dec (
        .word_i    (instr_i),
        .compact_i (enc_compact_i),
        .hit_o     (hit),
        .sb_err_o  (sb_err)
    );

    xret_legal_chk u_legal (
        .cur_mode_i (cur_mode_i),
        .tgt_mode_i (saved_status_i[MODE_W-1:0]),
        .illegal_o  (illegal)
    );

    xret_status_build u_sts (
        .saved_i    (saved_status_i),
        .cur_mode_i (cur_mode_i),
        .illegal_i  (illegal),
        .debug_i    (halted_i),
        .status_o   (sts_d)
    );

    assign in_usr = (cur_mode_i == MODE_USR);
    assign in_sys = (cur_mode_i == MODE_SYS);

    // next-state selection from the issuing cycle
    always_comb begin
        st_d  = ST_IDLE;
        unp_d = 1'b0;
        if (issue_i && hit) begin
            if (halted_i) begin
                if (!enc_compact_i) begin
                    st_d = ST_UNDEF;
                end else if (in_usr) begin
                    st_d = ST_UNDEF;
                end else if (in_sys) begin
                    st_d  = USS_OUT;
                    unp_d = 1'b1;
                end else begin
                    st_d = ST_DBG_RETURN;
                end
            end else if (cond_pass_i) begin
                if (in_usr || in_sys) begin
                    st_d  = USS_OUT;
                    unp_d = 1'b1;
                end else begin
                    st_d = ST_RETURN;
                end
                if (enc_compact_i && cb_active_i && !cb_last_i) unp_d = 1'b1;
            end
            if (st_d != ST_IDLE && sb_err) unp_d = 1'b1;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            unp_q <= 1'b0;
            tgt_q <= '0;
            sts_q <= '0;
        end else begin
            st_q  <= st_d;
            unp_q <= unp_d;
            tgt_q <= (cur_mode_i == MODE_HYP) ? hyp_link_i : gp_link_i;
            sts_q <= sts_d;
        end
    end

    // outputs from the held state
    always_comb begin
        br_take_o     = 1'b0;
        status_load_o = 1'b0;
        undef_o       = 1'b0;
        nop_o         = 1'b0;
        dbg_upd_o     = 1'b0;
        unique case (st_q)
            ST_IDLE:       ;
            ST_RETURN:     begin br_take_o = 1'b1; status_load_o = 1'b1; end
            ST_DBG_RETURN: begin status_load_o = 1'b1; dbg_upd_o = 1'b1; end
            ST_UNDEF:      undef_o = 1'b1;
            ST_NOP:        nop_o = 1'b1;
            default:       ;
        endcase
        unpred_o    = unp_q;
        br_target_o = br_take_o ? tgt_q : '0;
        status_o    = status_load_o ? sts_q : '0;
    end
endmodule

// File: rtl/xret_unit_chk.sv
`timescale 1ns/1ps
module xret_unit_chk
    import xret_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              issue_i,
    input logic              enc_compact_i,
    input logic              cond_pass_i,
    input logic [MODE_W-1:0] cur_mode_i,
    input logic              halted_i,
    input logic [XLEN-1:0]   hyp_link_i,
    input logic              br_take_o,
    input logic [XLEN-1:0]   br_target_o,
    input logic              status_load_o,
    input logic [XLEN-1:0]   status_o,
    input logic              undef_o,
    input logic              nop_o,
    input logic              unpred_o,
    input logic              dbg_upd_o
);
    assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_i |=> !br_take_o && !status_load_o && !undef_o && !nop_o && !unpred_o && !dbg_upd_o);

    assert_halt_no_branch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && halted_i) |=> !br_take_o);

    assert_cond_fail_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && !halted_i && !cond_pass_i) |=>
            !br_take_o && !status_load_o && !undef_o && !nop_o);

    assert_user_no_branch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && !halted_i && (cur_mode_i == MODE_USR || cur_mode_i == MODE_SYS)) |=>
            !br_take_o && !status_load_o);

    assert_fixed_halted_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && halted_i && !enc_compact_i) |=> !status_load_o);

    assert_one_outcome_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({br_take_o, undef_o, nop_o, dbg_upd_o}));

    assert_branch_loads_R5: assert property (@(posedge clk) disable iff (!rst_n)
        br_take_o |-> status_load_o);

    assert_hyp_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (br_take_o && $past(cur_mode_i) == MODE_HYP) |-> br_target_o == $past(hyp_link_i));

    assert_dbg_force_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_upd_o |-> (status_o[CB_HI:CB_LO] == '0) && status_o[ST_CSTATE]
                      && (status_o[FLG_HI:FLG_LO] == '0));
endmodule

bind xret_unit xret_unit_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .issue_i       (issue_i),
    .enc_compact_i (enc_compact_i),
    .cond_pass_i   (cond_pass_i),
    .cur_mode_i    (cur_mode_i),
    .halted_i      (halted_i),
    .hyp_link_i    (hyp_link_i),
    .br_take_o     (br_take_o),
    .br_target_o   (br_target_o),
    .status_load_o (status_load_o),
    .status_o      (status_o),
    .undef_o       (undef_o),
    .nop_o         (nop_o),
    .unpred_o      (unpred_o),
    .dbg_upd_o     (dbg_upd_o)
);

// File: tb/xret_unit_tb.sv
`timescale 1ns/1ps
module xret_unit_tb;
    typedef struct packed {
        logic        br;
        logic [31:0] tgt;
        logic        ld;
        logic [31:0] st;
        logic        und;
        logic        nop;
        logic        unp;
        logic        upd;
    } obs_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [31:0] instr = '0;
    logic        cpt = 1'b0;
    logic        cpass = 1'b0;
    logic [4:0]  mode = 5'b10011;
    logic        halt = 1'b0;
    logic        cba = 1'b0;
    logic        cbl = 1'b0;
    logic [31:0] hyl = '0;
    logic [31:0] gpl = '0;
    logic [31:0] sav = '0;
    obs_t        act;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    xret_unit u_dut (
        .clk(clk), .rst_n(rst_n), .issue_i(issue), .instr_i(instr),
        .enc_compact_i(cpt), .cond_pass_i(cpass), .cur_mode_i(mode),
        .halted_i(halt), .cb_active_i(cba), .cb_last_i(cbl),
        .hyp_link_i(hyl), .gp_link_i(gpl), .saved_status_i(sav),
        .br_take_o(act.br), .br_target_o(act.tgt), .status_load_o(act.ld),
        .status_o(act.st), .undef_o(act.und), .nop_o(act.nop),
        .unpred_o(act.unp), .dbg_upd_o(act.upd)
    );

    localparam logic [31:0] FIX_W = 32'hE160006E;
    localparam logic [31:0] CPT_W = 32'hF3DE8F00;

    function automatic bit known(input logic [4:0] m);
        return m inside {5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1A, 5'h1B, 5'h1F};
    endfunction

    function automatic int lvl(input logic [4:0] m);
        return (m == 5'h10) ? 0 : (m == 5'h1A) ? 2 : 1;
    endfunction

    function automatic obs_t model(output string tag);
        obs_t e = '0;
        bit hit, sb, ill;
        logic [31:0] s;
        tag = "R13";
        if (cpt) begin
            hit = ((instr & 32'hFFFFD0FF) == 32'hF3DE8000);
            sb  = ((instr & 32'h00002F00) != 32'h00000F00);
        end else begin
            hit = ((instr & 32'h0FF000F0) == 32'h01600060) && (instr[31:28] != 4'hF);
            sb  = ((instr & 32'h000FFF0F) != 32'h0000000E);
        end
        if (!issue) return e;
        tag = "R1";
        if (!hit) return e;
        ill = !known(sav[4:0]) || (lvl(sav[4:0]) > lvl(mode));
        s = sav;
        if (ill) begin s[4:0] = mode; s[20] = 1'b1; end
        if (halt) begin
            if (!cpt) begin e.und = 1; tag = "R11"; end
            else if (mode == 5'h10) begin e.und = 1; tag = "R9"; end
            else if (mode == 5'h1F) begin e.und = 1; e.unp = 1; tag = "R9"; end
            else begin
                s[15:8] = 8'h00; s[5] = 1'b1; s[31:27] = 5'h00;
                e.ld = 1; e.st = s; e.upd = 1; tag = ill ? "R12" : "R10";
            end
        end else begin
            tag = "R6";
            if (!cpass) return e;
            if (mode == 5'h10 || mode == 5'h1F) begin
                e.und = 1; e.unp = 1; tag = "R7";
            end else begin
                e.br = 1; e.ld = 1; e.st = s;
                e.tgt = (mode == 5'h1A) ? hyl : gpl;
                tag = ill ? "R12" : "R4";
            end
            if (cpt && cba && !cbl) begin e.unp = 1; tag = "R8"; end
        end
        if (sb) begin e.unp = 1; tag = "R3"; end
        return e;
    endfunction

    task automatic check(input obs_t exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        obs_t  exp;
        string tag;
        exp = model(tag);
        @(negedge clk);
        check(exp, tag);
    endtask

    task automatic drive(input logic [31:0] w, input logic c, input logic cp,
                         input logic [4:0] m, input logic h, input logic a,
                         input logic l, input logic [31:0] sv);
        issue = 1; instr = w; cpt = c; cpass = cp; mode = m; halt = h;
        cba = a; cbl = l; sav = sv;
        hyl = 32'h4000_1000; gpl = 32'h0000_2468;
        step();
        issue = 0;
    endtask

    logic [4:0] modes [10] = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17,
                               5'h1A, 5'h1B, 5'h1F, 5'h05, 5'h16};

    initial begin
        int seed = 32'h5EED;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        check('0, "R13");                                     // reset state
        rst_n = 1;
        @(negedge clk);
        step();                                               // R13 idle
        drive(32'hF160006E, 0, 1, 5'h13, 0, 0, 0, 32'h0000_0013); // R1 cond 1111
        drive(32'hE170006E, 0, 1, 5'h13, 0, 0, 0, 32'h0000_0013); // R1 opcode
        drive(32'hF3DE9F00, 1, 1, 5'h13, 0, 0, 0, 32'h0000_0013); // R2 reject
        drive(CPT_W, 1, 1, 5'h13, 0, 0, 0, 32'hA000_0011);      // R2 accept
        drive(FIX_W, 0, 1, 5'h1A, 0, 0, 0, 32'h8000_0013);      // R4 hyp
        drive(FIX_W, 0, 1, 5'h13, 0, 0, 0, 32'h6000_F013);      // R4/R5 svc
        drive(FIX_W ^ 32'h100, 0, 1, 5'h13, 0, 0, 0, 32'h13);   // R3
        drive(CPT_W ^ 32'h2000, 1, 1, 5'h13, 0, 0, 0, 32'h13);  // R3
        drive(FIX_W, 0, 0, 5'h13, 0, 0, 0, 32'h13);             // R6
        drive(FIX_W, 0, 1, 5'h10, 0, 0, 0, 32'h13);             // R7 user
        drive(FIX_W, 0, 1, 5'h1F, 0, 0, 0, 32'h13);             // R7 system
        drive(CPT_W, 1, 1, 5'h13, 0, 1, 0, 32'h13);             // R8
        drive(CPT_W, 1, 1, 5'h13, 0, 1, 1, 32'h13);             // R8 last
        drive(CPT_W, 1, 1, 5'h10, 1, 0, 0, 32'h10);             // R9 user
        drive(CPT_W, 1, 1, 5'h1F, 1, 0, 0, 32'h10);             // R9 system
        drive(CPT_W, 1, 0, 5'h13, 1, 0, 0, 32'hF800_FF12);      // R10
        drive(FIX_W, 0, 1, 5'h13, 1, 0, 0, 32'h13);             // R11
        drive(FIX_W, 0, 1, 5'h13, 0, 0, 0, 32'h0000_0005);      // R12 unknown
        drive(FIX_W, 0, 1, 5'h13, 0, 0, 0, 32'h0000_001A);      // R12 raise
        for (int i = 0; i < 4000; i++) begin
            int k = $urandom % 4;
            logic [31:0] w;
            logic        c;
            c = k[0];
            w = (k == 3) ? $urandom : (c ? CPT_W : {4'($urandom % 15), FIX_W[27:0]});
            if (($urandom % 4) == 0)
                w = w ^ ($urandom & (c ? 32'h00002F00 : 32'h000FFF0F));
            issue = ($urandom % 8) != 0; instr = w; cpt = c;
            cpass = ($urandom % 4) != 0; mode = modes[$urandom % 10];
            halt = ($urandom % 4) == 0; cba = $urandom; cbl = $urandom;
            hyl = $urandom; gpl = $urandom;
            sav = {$urandom, 5'b0} | 32'(modes[$urandom % 10]);
            step();
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #150000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule